// File: doc/BRIEF.md
# Width-12 Circulant Mixing Layer

This block performs the linear diffusion step of a 12-lane arithmetic hash permutation whose field is the prime p = 2^64 − 2^32 + 1. A whole 12-element state arrives on one wide bus. The block multiplies it by a fixed 12×12 matrix. That matrix is a circulant with small coefficients, plus a correction that touches only the top-left entry. The block returns 12 canonical field elements.

To avoid 64×64-bit multipliers, every input word is cut into four 16-bit chunks. Each chunk is weighted by the small coefficients and summed in its own 32-bit lane. A per-output fold then recombines the four lanes and reduces the result modulo p, using the identity 2^64 ≡ 2^32 − 1.

The block has one register stage, with a valid/ready handshake on the input side and on the output side. It adds no round constant. The round constants, the S-box and the round sequencing are handled outside this block.

Top module: `mds12_mixer`

## Requirements
- R1: Output element i (bits 64·i+63 down to 64·i of `res_data`) equals (Σ over r = 0..11 of c[r] · x[(i + r) mod 12]) mod p. The coefficients are c = (17, 15, 41, 16, 2, 28, 13, 13, 39, 18, 34, 20), x[k] is bits 64·k+63 down to 64·k of `src_data`, and p = 2^64 − 2^32 + 1. Output element 0 also includes the R2 term.
- R2: Output element 0 receives an extra 8 · x[0]. No other output receives any diagonal term.
- R3: Every output element is canonical, meaning strictly below p. This holds for every input word, including the all-ones word.
- R4: An input word at or above p is treated as its residue modulo p. For example, an input equal to p gives the same outputs as an input of 0.
- R5: Adding a constant is not part of this layer. An all-zero state produces an all-zero result.
- R6: A state accepted on a clock edge where `src_valid` and `src_ready` are both high appears on the next edge with `res_valid` high.
- R7: While `res_valid` is high and `res_ready` is low, `res_valid` stays high, `res_data` holds its value, and `src_ready` is low.
- R8: When `res_ready` is high, `src_ready` is high, so back-to-back states flow at one per cycle. After reset, `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | 1 | Input state is valid |
| src_ready | output | 1 | Block can take a state this cycle |
| src_data | input | 768 | Twelve 64-bit input elements, element k in bits 64k+63:64k |
| res_valid | output | 1 | Result state is valid |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_data | output | 768 | Twelve 64-bit canonical results, same element layout |

## Verification
The bench targets the following corner cases:

- **All-ones input.** This drives every lane to its largest sum, which stresses lane width and the two-step fold. A design with narrow lanes, or one that misses the fold carry, would return wrong words.
- **Single-hot inputs at element 0 and at an interior element.** These expose a rotated or mis-indexed coefficient row. They also show a diagonal term that is missing, or applied to the wrong output.
- **An input equal to p, and an input just above p.** These catch a fold that leaves non-canonical results.
- **A zero state.** This exposes any stray constant.

Under backpressure, the bench watches for a result that is dropped or changes while stalled.

// File: rtl/mds12_mixer.sv
module mds12_mixer #(
  parameter int N  = 12,
  parameter int EW = 64,
  parameter int CW = 16,
  parameter int LW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_valid,
  output logic            src_ready,
  input  logic [N*EW-1:0] src_data,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [N*EW-1:0] res_data
);
  localparam int NCH = EW / CW;
  localparam int SW  = EW + LW;
  localparam logic [EW-1:0] P   = 64'hFFFF_FFFF_0000_0001;
  localparam logic [EW-1:0] EPS = 64'h0000_0000_FFFF_FFFF;
  localparam int DIAG0 = 8;

  function automatic int coef(input int r);
    case (r)
      0: coef = 17;  1: coef = 15;  2: coef = 41;  3: coef = 16;
      4: coef = 2;   5: coef = 28;  6: coef = 13;  7: coef = 13;
      8: coef = 39;  9: coef = 18;  10: coef = 34; default: coef = 20;
    endcase
  endfunction

  function automatic logic [EW-1:0] fold(input logic [NCH*LW-1:0] l);
    logic [SW-1:0]    s;
    logic [SW-EW-1:0] hi;
    logic [EW:0]      t;
    logic [EW-1:0]    u;
    s = '0;
    for (int c = 0; c < NCH; c++) s = s + (SW'(l[c*LW +: LW]) << (c*CW));
    hi = s[SW-1:EW];
    t  = {1'b0, s[EW-1:0]} + (EW+1)'(hi) * (EW+1)'(EPS);
    u  = t[EW] ? (t[EW-1:0] + EPS) : t[EW-1:0];
    fold = (u >= P) ? (u - P) : u;
  endfunction

  logic [NCH*LW-1:0] lanes [N];
  logic [N*EW-1:0]   mixed;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      for (int c = 0; c < NCH; c++) begin
        logic [LW-1:0] acc;
        acc = '0;
        for (int r = 0; r < N; r++)
          acc = acc + LW'(coef(r)) * LW'(src_data[((i+r)%N)*EW + c*CW +: CW]);
        if (i == 0) acc = acc + LW'(DIAG0) * LW'(src_data[c*CW +: CW]);
        lanes[i][c*LW +: LW] = acc;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_fold
      assign mixed[g*EW +: EW] = fold(lanes[g]);
    end
  endgenerate

  assign src_ready = !res_valid || res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (src_valid && src_ready) begin
      res_valid <= 1'b1;
      res_data  <= mixed;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mds12_mixer_chk.sv
module mds12_mixer_chk #(
  parameter int N  = 12,
  parameter int EW = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            src_valid,
  input logic            src_ready,
  input logic [N*EW-1:0] src_data,
  input logic            res_valid,
  input logic            res_ready,
  input logic [N*EW-1:0] res_data
);
  localparam logic [EW-1:0] P = 64'hFFFF_FFFF_0000_0001;

  function automatic logic all_canon(input logic [N*EW-1:0] d);
    all_canon = 1'b1;
    for (int k = 0; k < N; k++) if (d[k*EW +: EW] >= P) all_canon = 1'b0;
  endfunction

  AST_CANONICAL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> all_canon(res_data)); // R3
  AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready && src_data == '0) |=> (res_data == '0)); // R5
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready) |=> res_valid); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data))); // R7
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !src_ready); // R7
  AST_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |-> src_ready); // R8
endmodule

bind mds12_mixer mds12_mixer_chk #(.N(N), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
  .src_data(src_data), .res_valid(res_valid), .res_ready(res_ready),
  .res_data(res_data)
);

// File: tb/mds12_mixer_bench.sv
module mds12_mixer_bench;
  localparam int N = 12;
  localparam int EW = 64;
  localparam logic [EW-1:0] P = 64'hFFFF_FFFF_0000_0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_valid = 1'b0;
  logic src_ready;
  logic [N*EW-1:0] src_data = '0;
  logic res_valid;
  logic res_ready = 1'b1;
  logic [N*EW-1:0] res_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mds12_mixer u_mds12_mixer (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data)
  );

  function automatic int cf(input int r);
    int t [12] = '{17, 15, 41, 16, 2, 28, 13, 13, 39, 18, 34, 20};
    cf = t[r];
  endfunction

  function automatic logic [N*EW-1:0] model(input logic [N*EW-1:0] x);
    logic [N*EW-1:0] y;
    for (int i = 0; i < N; i++) begin
      logic [95:0] acc;
      acc = '0;
      for (int r = 0; r < N; r++)
        acc = acc + 96'(cf(r)) * 96'(x[((i+r)%N)*EW +: EW]);
      if (i == 0) acc = acc + 96'(8) * 96'(x[0 +: EW]);
      y[i*EW +: EW] = EW'(acc % 96'(P));
    end
    return y;
  endfunction

  task automatic check(input string req, input logic [N*EW-1:0] got,
                       input logic [N*EW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      for (int k = 0; k < N; k++)
        if (got[k*EW +: EW] !== exp[k*EW +: EW]) begin
          $display("FAIL %s elem %0d got=%h exp=%h", req, k,
                   got[k*EW +: EW], exp[k*EW +: EW]);
          break;
        end
    end
  endtask

  task automatic check_bit(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic run(input string req, input logic [N*EW-1:0] x);
    @(negedge clk);
    src_data = x;
    src_valid = 1'b1;
    res_ready = 1'b1;
    @(posedge clk);
    #1 src_valid = 1'b0;
    @(negedge clk);
    check_bit({req, " valid"}, res_valid, 1'b1);
    check(req, res_data, model(x));
  endtask

  function automatic logic [N*EW-1:0] onehot(input int k, input logic [EW-1:0] v);
    logic [N*EW-1:0] d;
    d = '0;
    d[k*EW +: EW] = v;
    return d;
  endfunction

  initial begin
    logic [N*EW-1:0] v;
    logic [N*EW-1:0] held;
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    check_bit("R8 reset res_valid", res_valid, 1'b0);
    rst_n = 1'b1;

    run("R5 zero", '0);
    check("R5 zero literal", res_data, '0);
    run("R3 all ones", '1);
    run("R2 onehot0", onehot(0, 64'd1));
    v = '0;
    for (int k = 0; k < N; k++) v[k*EW +: EW] = 64'd0;
    v[0 +: EW] = 64'd1;
    check("R2 onehot0 literal", res_data,
          {64'd15, 64'd41, 64'd16, 64'd2, 64'd28, 64'd13,
           64'd13, 64'd39, 64'd18, 64'd34, 64'd20, 64'd25});
    run("R1 onehot5", onehot(5, 64'hDEAD_BEEF_1234_5678));
    run("R4 input p", onehot(3, P));
    check("R4 p same as zero", res_data, '0);
    run("R4 input p+7", onehot(7, P + 64'd7));
    run("R3 p-1 all", {N{P - 64'd1}});

    for (int t = 0; t < 20; t++) begin
      for (int k = 0; k < N; k++) v[k*EW +: EW] = {$urandom, $urandom};
      run("R1 random", v);
    end

    // backpressure
    for (int k = 0; k < N; k++) v[k*EW +: EW] = {$urandom, $urandom};
    @(negedge clk);
    res_ready = 1'b0;
    src_data = v;
    src_valid = 1'b1;
    @(posedge clk);
    #1 src_data = '1;
    @(negedge clk);
    held = res_data;
    check("R6 stalled result", held, model(v));
    repeat (3) begin
      @(negedge clk);
      check_bit("R7 held valid", res_valid, 1'b1);
      check_bit("R7 src_ready low", src_ready, 1'b0);
      check("R7 held data", res_data, held);
    end
    res_ready = 1'b1;
    #0.1;
    check_bit("R8 src_ready with res_ready", src_ready, 1'b1);
    @(posedge clk);
    #1;
    @(negedge clk);
    check("R8 next state", res_data, model('1));
    src_valid = 1'b0;
    @(negedge clk);
    check_bit("R8 drained", res_valid, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule